// File: doc/BRIEF.md
# Receive FIFO Fill-Level RTS Controller

This block produces the active-low request-to-send line of a serial receiver from the fill level of its 16-entry receive FIFO. It watches the push, pop and flush strobes of that FIFO and keeps its own count of how many entries are held. From that count it decides whether the far end may keep sending. A low level on `rts_n` means the far end may keep sending. A high level means it should pause.

The decision uses hysteresis. A 2-bit code selects a release level. When the count reaches that level, `rts_n` goes high. It stays high until the FIFO drains to a lower resume level, and only then drops low again. This avoids toggling the line on every byte near the threshold. When automatic operation is disabled, `rts_n` simply follows a software RTS bit. The hysteresis state still tracks the count while automatic operation is off, so it is correct whenever automatic operation is turned back on.

Top module: `rts_flow_ctrl`

## Requirements
- R1: After reset, `level` is 0 and, with `auto_en` set, `rts_n` is low.
- R2: On each clock edge without flush, the count changes as follows:
  - A push alone adds one.
  - A pop alone subtracts one.
  - A push and a pop together leave the count unchanged.
  - A push at a count of 16 is ignored.
  - A pop at a count of 0 is ignored.
  - The new count appears on `level` after that edge.
- R3: The release level is 1, 4, 8 or 14 entries for `trig_sel` codes 0, 1, 2 and 3. With `auto_en` set, `rts_n` is high after the edge on which the count becomes equal to or greater than the selected release level.
- R4: The resume level is 0, 1, 4 or 8 entries for `trig_sel` codes 0, 1, 2 and 3. Once `rts_n` is high, it stays high while the count is above the resume level. It goes low after the edge on which the count becomes equal to or less than the resume level.
- R5: A flush clears the count to 0 and drives `rts_n` low on the next clock edge. A flush takes priority over a push or a pop in the same cycle.
- R6: While `auto_en` is clear, `rts_n` is the inverse of `sw_rts`. The count and the hysteresis state keep following the FIFO strobes, so they take effect as soon as `auto_en` is set again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_en | input | 1 | Enables automatic RTS control |
| sw_rts | input | 1 | Software RTS request; 1 drives `rts_n` low when `auto_en` is clear |
| trig_sel | input | 2 | Release/resume level select code |
| push | input | 1 | One entry written into the receive FIFO |
| pop | input | 1 | One entry read from the receive FIFO |
| flush | input | 1 | Receive FIFO cleared |
| rts_n | output | 1 | Active-low request-to-send |
| level | output | 5 | Current FIFO occupancy, 0 to 16 |

## Verification
The assertions check the following on every cycle:
- The count stays within 0 to 16 and moves by at most one per cycle outside a flush.
- A push into a full FIFO holds the count at 16.
- A flush always ends with a zero count and a low hysteresis state.
- The hysteresis register sets, clears or holds according to the next count and the two selected levels.

The bench sweeps every select code through full fill and drain sequences and compares against its own arithmetic model. Only those scenarios can show that the release and resume levels match the required numbers for each code. They also show the manual override at the port and that the tracked state is correct when automatic mode returns.

// File: rtl/rts_flow_pkg.sv
package rts_flow_pkg;

   typedef enum logic [1:0] {
      TRIG_ONE      = 2'd0,
      TRIG_QUARTER  = 2'd1,
      TRIG_HALF     = 2'd2,
      TRIG_NEARFULL = 2'd3
   } trig_code_e;

   // Count at which the far end is told to pause.
   function automatic int unsigned release_level(input logic [1:0] code);
      case (code)
         TRIG_ONE:     return 1;
         TRIG_QUARTER: return 4;
         TRIG_HALF:    return 8;
         default:      return 14;
      endcase
   endfunction

   // Count at or below which sending may resume.
   function automatic int unsigned resume_level(input logic [1:0] code);
      case (code)
         TRIG_ONE:     return 0;
         TRIG_QUARTER: return 1;
         TRIG_HALF:    return 4;
         default:      return 8;
      endcase
   endfunction

endpackage

// File: rtl/rts_occupancy.sv
module rts_occupancy #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic             flush,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_nxt
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

   always_comb begin
      cnt_nxt = cnt_q;
      if (flush)
         cnt_nxt = '0;
      else if (push && !pop && cnt_q != FULL)
         cnt_nxt = cnt_q + 1'b1;
      else if (pop && !push && cnt_q != '0)
         cnt_nxt = cnt_q - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_nxt;
   end

   a_r2_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL);

   a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(flush) |-> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1
                         || cnt_q + 1'b1 == $past(cnt_q)));

   a_r2_full_push_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && !flush && cnt_q == FULL) |=> cnt_q == FULL);

   a_r5_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> cnt_q == '0);

endmodule

// File: rtl/rts_levels.sv
module rts_levels
   import rts_flow_pkg::*;
#(
   parameter int unsigned CNT_W = 5
) (
   input  logic [1:0]       code,
   output logic [CNT_W-1:0] hi_lvl,
   output logic [CNT_W-1:0] lo_lvl
);
   localparam int unsigned NCODES = 4;

   logic [CNT_W-1:0] hi_tab [NCODES];
   logic [CNT_W-1:0] lo_tab [NCODES];

   for (genvar g = 0; g < NCODES; g++) begin : g_tab
      assign hi_tab[g] = CNT_W'(release_level(2'(g)));
      assign lo_tab[g] = CNT_W'(resume_level(2'(g)));
   end

   assign hi_lvl = hi_tab[code];
   assign lo_lvl = lo_tab[code];

   always_comb begin
      a_r4_ordered: assert (lo_lvl < hi_lvl);
   end

endmodule

// File: rtl/rts_hyst.sv
module rts_hyst #(
   parameter int unsigned CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [CNT_W-1:0] cnt_nxt,
   input  logic [CNT_W-1:0] hi_lvl,
   input  logic [CNT_W-1:0] lo_lvl,
   output logic             held_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                held_q <= 1'b0;
      else if (flush)            held_q <= 1'b0;
      else if (cnt_nxt >= hi_lvl) held_q <= 1'b1;
      else if (cnt_nxt <= lo_lvl) held_q <= 1'b0;
   end

   a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && cnt_nxt >= hi_lvl) |=> held_q);

   a_r4_resume: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && cnt_nxt <= lo_lvl) |=> !held_q);

   a_r4_band_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && cnt_nxt > lo_lvl && cnt_nxt < hi_lvl) |=> $stable(held_q));

   a_r5_flush_resumes: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !held_q);

endmodule

// File: rtl/rts_flow_ctrl.sv
module rts_flow_ctrl
   import rts_flow_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             auto_en,
   input  logic             sw_rts,
   input  logic [1:0]       trig_sel,
   input  logic             push,
   input  logic             pop,
   input  logic             flush,
   output logic             rts_n,
   output logic [CNT_W-1:0] level
);
   if (DEPTH < 14) begin : g_bad_depth
      $error("DEPTH must cover the highest release level");
   end
   if ((1 << CNT_W) <= DEPTH) begin : g_bad_width
      $error("CNT_W too narrow for DEPTH");
   end

   logic [CNT_W-1:0] cnt_q, cnt_nxt, hi_lvl, lo_lvl;
   logic             held_q;

   rts_occupancy #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_occ (
      .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .flush(flush),
      .cnt_q(cnt_q), .cnt_nxt(cnt_nxt)
   );

   rts_levels #(.CNT_W(CNT_W)) u_lvl (
      .code(trig_sel), .hi_lvl(hi_lvl), .lo_lvl(lo_lvl)
   );

   rts_hyst #(.CNT_W(CNT_W)) u_hyst (
      .clk(clk), .rst_n(rst_n), .flush(flush), .cnt_nxt(cnt_nxt),
      .hi_lvl(hi_lvl), .lo_lvl(lo_lvl), .held_q(held_q)
   );

   assign rts_n = auto_en ? held_q : ~sw_rts;
   assign level = cnt_q;

   a_r1_empty_low: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && level == '0) |-> !rts_n);

endmodule

// File: tb/test_rts_flow_ctrl.sv
module test_rts_flow_ctrl;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       auto_en = 1'b1, sw_rts = 1'b0;
   logic [1:0] trig_sel = 2'd0;
   logic       push = 1'b0, pop = 1'b0, flush = 1'b0;
   logic       rts_n;
   logic [4:0] level;

   int checks = 0, failures = 0;
   int m_cnt = 0;
   bit m_held = 1'b0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rts_flow_ctrl i_rts_flow_ctrl (
      .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .sw_rts(sw_rts),
      .trig_sel(trig_sel), .push(push), .pop(pop), .flush(flush),
      .rts_n(rts_n), .level(level)
   );

   function automatic int rel_of(input int c);
      return (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : 14;
   endfunction
   function automatic int res_of(input int c);
      return (c == 0) ? 0 : (c == 1) ? 1 : (c == 2) ? 4 : 8;
   endfunction

   task automatic check(input string tag);
      bit exp_rts;
      exp_rts = auto_en ? m_held : !sw_rts;
      checks++;
      if (int'(level) != m_cnt || rts_n != exp_rts) begin
         failures++;
         $display("FAIL %s: level=%0d rts_n=%0b expected level=%0d rts_n=%0b",
                  tag, level, rts_n, m_cnt, exp_rts);
      end
   endtask

   task automatic step(input bit pu, input bit po, input bit fl, input string tag);
      @(negedge clk);
      push = pu; pop = po; flush = fl;
      @(posedge clk);
      #1;
      if (fl) m_cnt = 0;
      else if (pu && !po && m_cnt < 16) m_cnt++;
      else if (po && !pu && m_cnt > 0) m_cnt--;
      if (fl) m_held = 1'b0;
      else if (m_cnt >= rel_of(int'(trig_sel))) m_held = 1'b1;
      else if (m_cnt <= res_of(int'(trig_sel))) m_held = 1'b0;
      check(tag);
      @(negedge clk);
      push = 1'b0; pop = 1'b0; flush = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run did not complete");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1");

      for (int c = 0; c < 4; c++) begin
         trig_sel = 2'(c);
         step(1'b0, 1'b0, 1'b1, "R5");
         for (int k = 0; k < 16; k++) step(1'b1, 1'b0, 1'b0, "R3");
         step(1'b1, 1'b0, 1'b0, "R2");   // push while full
         step(1'b1, 1'b1, 1'b0, "R2");   // push and pop together
         for (int k = 0; k < 16; k++) step(1'b0, 1'b1, 1'b0, "R4");
         step(1'b0, 1'b1, 1'b0, "R2");   // pop while empty
         // bounce around the band: up to release, down one, up one
         for (int k = 0; k < rel_of(c); k++) step(1'b1, 1'b0, 1'b0, "R3");
         step(1'b0, 1'b1, 1'b0, "R4");
         step(1'b1, 1'b0, 1'b0, "R3");
         step(1'b1, 1'b1, 1'b0, "R2");
         step(1'b1, 1'b0, 1'b1, "R5");   // flush wins over push
      end

      // manual mode
      trig_sel = 2'd2;
      auto_en = 1'b0;
      sw_rts = 1'b1;
      for (int k = 0; k < 9; k++) step(1'b1, 1'b0, 1'b0, "R6");
      sw_rts = 1'b0;
      step(1'b0, 1'b0, 1'b0, "R6");
      sw_rts = 1'b1;
      step(1'b0, 1'b1, 1'b0, "R6");
      auto_en = 1'b1;
      #1;
      check("R6");                       // state tracked while off: count 8, held
      for (int k = 0; k < 4; k++) step(1'b0, 1'b1, 1'b0, "R4");
      step(1'b0, 1'b0, 1'b1, "R5");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule